// File: doc/BRIEF.md
# Edge-Triggered Multi-Pin Wakeup Controller

This block watches eight general-purpose input pins and raises a per-pin pending flag when a pin makes a programmed transition. Each pin can be enabled on its own, and each can be set to react to either a rising or a falling transition. Every raw input passes through a two-flop synchroniser. A transition is found by comparing the synchronised level with its value one cycle earlier.

All pending flags are ORed into one wakeup output for the low-power sequencer. The same OR, gated by an interrupt-enable bit, drives a single shared interrupt request. A "sleep allowed" output is high only when no flag is pending, so the power sequencer can refuse entry into the halt and idle states. Software cannot set a flag; it can only clear one. Channel 6 can take an internal fault signal in place of pin 6, and this is meant to be used with rising-edge selection.

Each channel is a two-state machine. In CH_IDLE the flag is clear. The transition IDLE-to-PEND is taken on a qualifying edge while the channel is enabled. The transition PEND-to-IDLE is taken on a software clear in a cycle with no qualifying edge. In every other case the channel holds its state.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset, the enable, edge-select, pending and control registers read 0. The outputs are wake_o=0, irq_o=0 and sleep_ok_o=1.
- R2: The bus address selects the register. Address 0 is enable, 1 is edge-select, 2 is pending and 3 is control. In the control register, bit 0 is the interrupt enable and bit 1 is the channel 6 source select. The other control bits read as 0. A read returns the current contents in the same cycle.
- R3: A channel whose enable bit is 0 never sets its pending flag, whatever its pin does.
- R4: With edge-select bit 0, a rising transition sets the flag. With edge-select bit 1, a falling transition sets it. A transition of the opposite direction does nothing. A pin level first captured at rising clock edge k sets the flag at edge k+2.
- R5: A write to address 2 clears every pending bit written as 0 and leaves every bit written as 1 unchanged. For example, 0xF7 clears only bit 3. A write can never set a flag.
- R6: When a qualifying edge and a clearing write reach the same bit at the same clock edge, the bit ends up set.
- R7: wake_o is high exactly when at least one pending bit is 1.
- R8: irq_o equals wake_o AND the interrupt enable. It stays high until every pending bit is cleared.
- R9: sleep_ok_o is high exactly when the pending register is all zero.
- R10: When the source select is 1, channel 6 follows fault_i and ignores pin_i[6]. When it is 0, channel 6 follows pin_i[6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 8 | Asynchronous general-purpose pin levels |
| fault_i | input | 1 | Internal fault signal that can replace pin 6 |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wake_o | output | 1 | OR of all pending flags |
| irq_o | output | 1 | Shared interrupt request |
| sleep_ok_o | output | 1 | High when no flag is pending |

## Verification
A hardware edge can set a pending bit at the same clock edge where a software write clears it. The synchroniser latency is fixed, so the bench provokes this directly: it issues a pending-register write of 0x00 so that the write lands on the edge where a freshly captured rising edge on pin 0 sets its flag. At that same edge, an older flag on pin 1 is cleared. The bench judges the result by reading back 0x01, which shows the clear took effect and the set took priority. The random phase mixes writes of random clear masks with random pin activity so that the two collide many more times. Each collision is judged against a bench model built from R4 to R6.

// File: rtl/ewk_pkg.sv
package ewk_pkg;
    localparam int unsigned NPINS       = 8;
    localparam int unsigned ADDR_W      = 2;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned SUB_CH      = 6;
    localparam int unsigned CTRL_W      = 2;
    localparam int unsigned CTRL_IRQ_EN = 0;
    localparam int unsigned CTRL_SRC    = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 2'd0,
        REG_EDGE   = 2'd1,
        REG_PEND   = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;
endpackage

// File: rtl/ewk_sync.sv
module ewk_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    // per-bit synchroniser chain followed by a one-cycle history register
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              hist_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                hist_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d[g]};
                hist_q  <= chain_q[STAGES-1];
            end
        end

        assign cur[g]  = chain_q[STAGES-1];
        assign prev[g] = hist_q;
    end
endmodule

// File: rtl/ewk_channel.sv
module ewk_channel
    import ewk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fall_sel,
    input  logic level_now,
    input  logic level_old,
    input  logic clear_req,
    output logic pending
);
    ch_state_e state_q, state_d;
    logic      edge_hit;

    // qualifying transition for this channel
    always_comb begin
        if (fall_sel) edge_hit = enable & level_old & ~level_now;
        else          edge_hit = enable & ~level_old & level_now;
    end

    // next-state logic: an edge outranks a clear in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (edge_hit)                state_d = CH_PEND;
            CH_PEND: if (clear_req && !edge_hit)  state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb pending = (state_q == CH_PEND);
endmodule

// File: rtl/ewk_regs.sv
module ewk_regs
    import ewk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  pend,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  edge_q,
    output logic              irq_en,
    output logic              src_sel,
    output logic [NPINS-1:0]  clr_mask,
    output logic [NPINS-1:0]  rdata
);
    logic [CTRL_W-1:0] ctrl_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            edge_q <= '0;
            ctrl_q <= '0;
        end else if (we) begin
            unique case (sel)
                REG_ENABLE: en_q   <= wdata;
                REG_EDGE:   edge_q <= wdata;
                REG_PEND:   ;
                REG_CTRL:   ctrl_q <= wdata[CTRL_W-1:0];
            endcase
        end
    end

    // zeros in a pending write request a clear, ones leave the bit alone
    always_comb begin
        clr_mask = '0;
        if (we && sel == REG_PEND) clr_mask = ~wdata;
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_ENABLE: rdata = en_q;
            REG_EDGE:   rdata = edge_q;
            REG_PEND:   rdata = pend;
            REG_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
        endcase
    end

    assign irq_en  = ctrl_q[CTRL_IRQ_EN];
    assign src_sel = ctrl_q[CTRL_SRC];
endmodule

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl
    import ewk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              fault_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              wake_o,
    output logic              irq_o,
    output logic              sleep_ok_o
);
    logic [NPINS-1:0] en_q, edge_q, clr_mask, pend_q;
    logic [NPINS-1:0] chan_raw, lvl_now, lvl_old;
    logic             irq_en, src_sel;

    ewk_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pend     (pend_q),
        .en_q     (en_q),
        .edge_q   (edge_q),
        .irq_en   (irq_en),
        .src_sel  (src_sel),
        .clr_mask (clr_mask),
        .rdata    (bus_rdata)
    );

    // channel SUB_CH may take the internal fault source ahead of synchronisation
    always_comb begin
        chan_raw         = pin_i;
        chan_raw[SUB_CH] = src_sel ? fault_i : pin_i[SUB_CH];
    end

    ewk_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chan_raw),
        .cur   (lvl_now),
        .prev  (lvl_old)
    );

    for (genvar c = 0; c < NPINS; c++) begin : g_chan
        ewk_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (en_q[c]),
            .fall_sel  (edge_q[c]),
            .level_now (lvl_now[c]),
            .level_old (lvl_old[c]),
            .clear_req (clr_mask[c]),
            .pending   (pend_q[c])
        );
    end

    assign wake_o     = |pend_q;
    assign irq_o      = wake_o & irq_en;
    assign sleep_ok_o = ~wake_o;
endmodule

// File: rtl/ewk_checker.sv
module ewk_checker
    import ewk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  pend_q,
    input logic              wake_o,
    input logic              irq_o,
    input logic              sleep_ok_o
);
    logic [NPINS-1:0] bus_clr;
    assign bus_clr = (bus_we && bus_addr == REG_PEND) ? ~bus_wdata : '0;

    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (en_q == '0 && pend_q == '0 && !irq_o && sleep_ok_o));

    p_no_set_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) & ~$past(en_q)) == '0);

    p_clear_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q) & ~pend_q) & ~$past(bus_clr)) == '0);

    p_irq_implies_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);

    p_sleep_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ok_o |-> !wake_o);
endmodule

bind edge_wake_ctrl ewk_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .wake_o     (wake_o),
    .irq_o      (irq_o),
    .sleep_ok_o (sleep_ok_o)
);

// File: tb/sim_edge_wake_ctrl.sv
`timescale 1ns/1ps
module sim_edge_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = 8'h00;
    logic       fault_i = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wake_o, irq_o, sleep_ok_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [7:0] m_en, m_edge, m_pend, m_s1, m_s2, m_prev;
    logic [1:0] m_ctrl;

    always #10 clk = ~clk;

    edge_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .fault_i(fault_i),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wake_o(wake_o), .irq_o(irq_o),
        .sleep_ok_o(sleep_ok_o)
    );

    function automatic logic [7:0] reg_view(input logic [1:0] a);
        case (a)
            2'd0:    return m_en;
            2'd1:    return m_edge;
            2'd2:    return m_pend;
            default: return {6'b0, m_ctrl};
        endcase
    endfunction

    function automatic logic [10:0] expect_vec(input logic [1:0] a);
        logic w;
        w = |m_pend;
        return {w, w & m_ctrl[0], ~w, reg_view(a)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_edge = 0; m_pend = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_ctrl = 0;
    endtask

    task automatic model_clock(input logic [7:0] p, input logic f, input logic we,
                               input logic [1:0] a, input logic [7:0] d);
        logic [7:0] in_v, set_v, clr_v;
        in_v = p;
        in_v[6] = m_ctrl[1] ? f : p[6];
        set_v = m_en & ((m_edge & m_prev & ~m_s2) | (~m_edge & m_s2 & ~m_prev));
        clr_v = (we && a == 2'd2) ? ~d : 8'h00;
        m_pend = (m_pend & ~clr_v) | set_v;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = in_v;
        if (we) begin
            case (a)
                2'd0: m_en = d;
                2'd1: m_edge = d;
                2'd3: m_ctrl = d[1:0];
                default: ;
            endcase
        end
    endtask

    // one clock: drive at negedge, update model at posedge, compare mid-cycle
    task automatic step(input logic [7:0] p, input logic f, input logic we,
                        input logic [1:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        pin_i = p; fault_i = f; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_clock(p, f, we, a, d);
        #5;
        chk(tag, {21'b0, wake_o, irq_o, sleep_ok_o, bus_rdata}, {21'b0, expect_vec(a)});
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        step(pin_i, fault_i, 1'b1, a, d, tag);
    endtask

    task automatic idle(input int n, input logic [1:0] a, input string tag);
        for (int i = 0; i < n; i++) step(pin_i, fault_i, 1'b0, a, 8'h00, tag);
    endtask

    task automatic rd_lit(input logic [1:0] a, input logic [7:0] exp, input string tag);
        step(pin_i, fault_i, 1'b0, a, 8'h00, tag);
        chk(tag, {24'b0, bus_rdata}, {24'b0, exp});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) rd_lit(2'(a), 8'h00, "R1 reset register");
        chk("R1 sleep_ok after reset", {31'b0, sleep_ok_o}, 32'd1);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'd0);

        // R2: register map and read-back
        wr(2'd0, 8'hA5, "R2 enable write"); rd_lit(2'd0, 8'hA5, "R2 enable read");
        wr(2'd1, 8'h3C, "R2 edge write");   rd_lit(2'd1, 8'h3C, "R2 edge read");
        wr(2'd3, 8'hFF, "R2 ctrl write");   rd_lit(2'd3, 8'h03, "R2 ctrl read");
        wr(2'd3, 8'h00, "R2 ctrl clear");   wr(2'd1, 8'h00, "R2 edge clear");

        // R3/R4: only enabled rising edges, latency two edges after capture
        wr(2'd0, 8'h0F, "R3 enable low nibble");
        step(8'hFF, 1'b0, 1'b0, 2'd2, 8'h00, "R4 capture");
        chk("R4 not yet at capture+1", {24'b0, bus_rdata}, 32'h00);
        step(8'hFF, 1'b0, 1'b0, 2'd2, 8'h00, "R4 sync");
        chk("R4 not yet at capture+1", {24'b0, bus_rdata}, 32'h00);
        step(8'hFF, 1'b0, 1'b0, 2'd2, 8'h00, "R4 set");
        chk("R3 R4 only enabled pins set", {24'b0, bus_rdata}, 32'h0F);
        chk("R7 wake with pending", {31'b0, wake_o}, 32'd1);

        // R5: write-zero-to-clear
        wr(2'd2, 8'hF7, "R5 clear bit3"); rd_lit(2'd2, 8'h07, "R5 0xF7 clears only bit3");
        wr(2'd2, 8'hFF, "R5 ones keep");  rd_lit(2'd2, 8'h07, "R5 ones keep flags");
        wr(2'd2, 8'hF8, "R5 clear rest"); rd_lit(2'd2, 8'h00, "R5 all cleared");
        chk("R9 sleep_ok when clear", {31'b0, sleep_ok_o}, 32'd1);

        // R4: falling selection
        wr(2'd1, 8'h0F, "R4 falling select");
        step(8'h00, 1'b0, 1'b0, 2'd2, 8'h00, "R4 fall");
        idle(3, 2'd2, "R4 fall wait");
        rd_lit(2'd2, 8'h0F, "R4 falling edge sets");
        wr(2'd2, 8'h00, "R4 clear");
        wr(2'd0, 8'hFF, "R4 enable all"); wr(2'd1, 8'hFF, "R4 all falling");
        step(8'hFF, 1'b0, 1'b0, 2'd2, 8'h00, "R4 rise with falling sel");
        idle(3, 2'd2, "R4 wait");
        rd_lit(2'd2, 8'h00, "R4 rising ignored when falling selected");

        // R8: shared interrupt
        wr(2'd3, 8'h01, "R8 irq enable");
        wr(2'd0, 8'h01, "R8 enable bit0"); wr(2'd1, 8'h01, "R8 bit0 falling");
        step(8'hFE, 1'b0, 1'b0, 2'd2, 8'h00, "R8 drop pin0");
        idle(3, 2'd2, "R8 wait");
        chk("R8 irq raised", {31'b0, irq_o}, 32'd1);
        idle(2, 2'd2, "R8 irq held");
        chk("R8 irq held while pending", {31'b0, irq_o}, 32'd1);
        wr(2'd2, 8'hFE, "R8 clear");
        chk("R8 irq drops after clear", {31'b0, irq_o}, 32'd0);

        // R6: collision of set and clear
        wr(2'd1, 8'h00, "R6 rising"); wr(2'd0, 8'h03, "R6 enable bits 0,1");
        step(8'hFC, 1'b0, 1'b0, 2'd2, 8'h00, "R6 lower pin1");
        idle(3, 2'd2, "R6 wait");
        step(8'hFE, 1'b0, 1'b0, 2'd2, 8'h00, "R6 raise pin1");
        idle(3, 2'd2, "R6 wait");
        rd_lit(2'd2, 8'h02, "R6 pin1 flag set");
        step(8'hFF, 1'b0, 1'b0, 2'd2, 8'h00, "R6 raise pin0");
        step(8'hFF, 1'b0, 1'b0, 2'd2, 8'h00, "R6 sync");
        step(8'hFF, 1'b0, 1'b1, 2'd2, 8'h00, "R6 clear on set edge");
        chk("R6 set wins over clear", {24'b0, bus_rdata}, 32'h01);
        wr(2'd2, 8'h00, "R6 clear");

        // R10: source substitution on channel 6
        wr(2'd0, 8'h40, "R10 enable ch6"); wr(2'd3, 8'h02, "R10 select fault");
        idle(3, 2'd2, "R10 settle");
        step(8'hBF, 1'b0, 1'b0, 2'd2, 8'h00, "R10 pin6 low");
        idle(3, 2'd2, "R10 wait");
        step(8'hFF, 1'b0, 1'b0, 2'd2, 8'h00, "R10 pin6 high");
        idle(3, 2'd2, "R10 wait");
        rd_lit(2'd2, 8'h00, "R10 pin6 ignored when substituted");
        step(8'hFF, 1'b1, 1'b0, 2'd2, 8'h00, "R10 fault rise");
        idle(3, 2'd2, "R10 wait");
        rd_lit(2'd2, 8'h40, "R10 fault sets ch6");
        wr(2'd2, 8'h00, "R10 clear");

        // random phase: R3 R4 R5 R6 R7 R8 R9 R10 against model
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] p;
            logic       f, we;
            logic [1:0] a;
            logic [7:0] d;
            p  = ($urandom % 4 == 0) ? 8'($urandom) : pin_i;
            f  = ($urandom % 5 == 0) ? ~fault_i : fault_i;
            we = ($urandom % 4 == 0);
            a  = 2'($urandom);
            d  = 8'($urandom);
            if (we && a == 2'd2 && ($urandom % 2 == 0)) d = 8'h00;
            step(p, f, we, a, d, "R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule